// File: doc/BRIEF.md
# 100 Mb/s Transmit Line Encoder

This block sits between the nibble-wide transmit side of a media-independent interface and the line driver of a 100 Mb/s twisted-pair port. A nibble and its frame-enable and error flags are taken in once every five bit times. Each nibble is turned into a 5-bit code-group, and the start and end delimiters and the idle fill are inserted at the frame edges. The code-groups are sent out serially, most significant bit first, and masked with an 11-bit pseudo-random keystream. The stream is then NRZI coded and finally split into the two drive phases of a three-level (MLT-3) line signal.

The block runs on the bit clock. The surrounding logic pulses `nib_en` every fifth cycle to mark a symbol boundary, and the nibble inputs are sampled on that cycle. The keystream seed is taken from the port address while reset is held, so that ports sharing one board send different idle patterns. Two static controls skip the code-group mapping or the keystream masking, for test and for external coding.

Top module: `tx_pcs_encoder`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, both `line_plus` and `line_minus` are low. The line stays at its zero level until the stream carries a one.
- R2: When `tx_en` is sampled high in the idle state, the first symbol sent is J = 11000. The next symbol is K = 10001, whatever nibble is present. Together these two replace the first two preamble nibbles.
- R3: Every later nibble of a frame is sent as its 4B5B code-group, most significant bit first: 0=11110 1=01001 2=10100 3=10101 4=01010 5=01011 6=01110 7=01111 8=10010 9=10011 A=10110 B=10111 C=11010 D=11011 E=11100 F=11101.
- R4: A data symbol sampled with both `tx_en` and `tx_er` high is sent as HALT = 00100 instead of its data code-group.
- R5: The first symbol sampled with `tx_en` low after data is T = 01101. The next symbol is R = 00111. From then on IDLE = 11111 is sent until `tx_en` is sampled high again.
- R6: The keystream comes from an 11-bit register s. While reset is held, s[i] is loaded with `phy_addr[i mod 5]`, and the value 11'h7FF is used in place of zero. On every cycle the key bit is k = s[10]^s[8], s shifts left by one, and k enters at bit 0. The bit that is sent is the code bit XOR k.
- R7: The scrambled bit is NRZI coded: a one inverts the internal line level, and a zero leaves it unchanged.
- R8: Each NRZI inversion moves the MLT-3 level one step around the cycle 0, +1, 0, -1. `line_plus` is high only at +1, and `line_minus` is high only at -1. The two are never high together.
- R9: With `bypass_code` high, each symbol is the raw group {tx_er, txd[3:0]}, with no delimiters and no idle substitution.
- R10: With `bypass_scr` high, code bits reach the NRZI stage without the keystream mask, but the keystream register keeps stepping.
- R11: A code-group loaded at the `nib_en` edge E0 places its MSB in the stream for the cycle after E0. A one in that bit changes the outputs two edges after E0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nib_en | input | 1 | Symbol boundary pulse, one cycle in five |
| txd | input | 4 | Transmit nibble |
| tx_en | input | 1 | Frame enable |
| tx_er | input | 1 | Transmit error, forces HALT inside a frame |
| phy_addr | input | 5 | Port address, used as keystream seed during reset |
| bypass_code | input | 1 | Send raw 5-bit groups instead of mapped code-groups |
| bypass_scr | input | 1 | Skip keystream masking |
| line_plus | output | 1 | Drive phase for the +1 level |
| line_minus | output | 1 | Drive phase for the -1 level |

## Verification
With the keystream bypassed, the bench recovers the bit stream from the two drive phases and looks for J/K, each data code-group, HALT, and T/R followed by idle. This separates wrong mappings, wrong delimiter order and wrong bit order. Runs with the keystream enabled and two port addresses, one of them zero, distinguish the seed rule, the tap positions and the forced non-zero seed. A raw-group run with mixed error flags shows that the mapping bypass passes all five bits unchanged. Every cycle is also compared against a behavioural model, so any latency slip or wrong MLT-3 step is reported.

// File: rtl/tx_pcs_pkg.sv
package tx_pcs_pkg;

    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_K    = 2'd1,
        FR_DATA = 2'd2,
        FR_R    = 2'd3
    } fr_state_e;

    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0] CG_J    = 5'b11000;
    localparam logic [CG_W-1:0] CG_K    = 5'b10001;
    localparam logic [CG_W-1:0] CG_T    = 5'b01101;
    localparam logic [CG_W-1:0] CG_R    = 5'b00111;
    localparam logic [CG_W-1:0] CG_HALT = 5'b00100;

    function automatic logic [CG_W-1:0] nib_to_cg(input logic [NIB_W-1:0] n);
        logic [CG_W-1:0] c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tx_pcs_framer.sv
module tx_pcs_framer
    import tx_pcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_en,
    input  logic [NIB_W-1:0] txd,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic             bypass_code,
    output logic             ser_bit
);

    typedef struct packed {
        fr_state_e       st;
        logic [CG_W-1:0] sh;
    } fr_t;

    fr_t             fr_d, fr_q;
    fr_state_e       st_next;
    logic [CG_W-1:0] cg_sel;

    always_comb begin
        fr_d    = fr_q;
        st_next = fr_q.st;
        cg_sel  = CG_IDLE;
        unique case (fr_q.st)
            FR_IDLE: begin
                if (tx_en) begin
                    cg_sel  = CG_J;
                    st_next = FR_K;
                end
            end
            FR_K: begin
                cg_sel  = CG_K;
                st_next = FR_DATA;
            end
            FR_DATA: begin
                if (!tx_en) begin
                    cg_sel  = CG_T;
                    st_next = FR_R;
                end else if (tx_er) begin
                    cg_sel  = CG_HALT;
                end else begin
                    cg_sel  = nib_to_cg(txd);
                end
            end
            FR_R: begin
                cg_sel  = CG_R;
                st_next = FR_IDLE;
            end
        endcase
        if (bypass_code) begin
            cg_sel = {tx_er, txd};
        end
        if (nib_en) begin
            fr_d.st = st_next;
            fr_d.sh = cg_sel;
        end else begin
            fr_d.sh = {fr_q.sh[CG_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q.st <= FR_IDLE;
            fr_q.sh <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign ser_bit = fr_q.sh[CG_W-1];

    // R2: a frame start is followed by K
    a_r2_k_after_j: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_en && fr_q.st == FR_IDLE && tx_en) |=> (fr_q.st == FR_K));

    // R5: end of data leads to R
    a_r5_t_then_r: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_en && fr_q.st == FR_DATA && !tx_en) |=> (fr_q.st == FR_R));

    // R11: bits move one place per cycle between symbol loads
    a_r11_serial_shift: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(nib_en)) |-> (fr_q.sh[CG_W-1:1] == $past(fr_q.sh[CG_W-2:0])));

endmodule

// File: rtl/tx_pcs_scrambler.sv
module tx_pcs_scrambler #(
    parameter int ADDR_W   = 5,
    parameter int LFSR_W   = 11,
    parameter int LFSR_TAP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              bypass,
    input  logic              din,
    output logic              dout
);

    typedef struct packed {
        logic [LFSR_W-1:0] s;
    } scr_t;

    scr_t              scr_d, scr_q;
    logic [LFSR_W-1:0] seed_raw;
    logic [LFSR_W-1:0] seed;
    logic              key;

    for (genvar i = 0; i < LFSR_W; i++) begin : g_seed
        assign seed_raw[i] = phy_addr[i % ADDR_W];
    end

    assign seed = (seed_raw == '0) ? '1 : seed_raw;

    always_comb begin
        scr_d   = scr_q;
        key     = scr_q.s[LFSR_W-1] ^ scr_q.s[LFSR_TAP];
        scr_d.s = {scr_q.s[LFSR_W-2:0], key};
        dout    = din ^ (key & ~bypass);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scr_q.s <= seed;
        end else begin
            scr_q <= scr_d;
        end
    end

    // R6: register never reaches the locked all-zero state
    a_r6_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        scr_q.s != '0);

    // R6: register shifts by one place every cycle
    a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (scr_q.s[LFSR_W-1:1] == $past(scr_q.s[LFSR_W-2:0])));

endmodule

// File: rtl/tx_pcs_mlt3.sv
module tx_pcs_mlt3 (
    input  logic clk,
    input  logic rst_n,
    input  logic sbit,
    output logic line_plus,
    output logic line_minus
);

    typedef struct packed {
        logic       nrzi;
        logic       nrzi_prev;
        logic [1:0] phase;
    } ln_t;

    ln_t ln_d, ln_q;

    always_comb begin
        ln_d           = ln_q;
        ln_d.nrzi      = ln_q.nrzi ^ sbit;
        ln_d.nrzi_prev = ln_q.nrzi;
        if (ln_q.nrzi != ln_q.nrzi_prev) begin
            ln_d.phase = ln_q.phase + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign line_plus  = (ln_q.phase == 2'd1);
    assign line_minus = (ln_q.phase == 2'd3);

    // R7: a one inverts the NRZI level
    a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sbit)) |-> (ln_q.nrzi != $past(ln_q.nrzi)));

    // R8: level only steps forward around the cycle
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ln_q.phase != $past(ln_q.phase)) |-> (ln_q.phase == $past(ln_q.phase) + 2'd1));

    // R8: phases are exclusive
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_plus && line_minus));

endmodule

// File: rtl/tx_pcs_encoder.sv
module tx_pcs_encoder #(
    parameter int ADDR_W   = 5,
    parameter int LFSR_W   = 11,
    parameter int LFSR_TAP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_en,
    input  logic [3:0]        txd,
    input  logic              tx_en,
    input  logic              tx_er,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              bypass_code,
    input  logic              bypass_scr,
    output logic              line_plus,
    output logic              line_minus
);

    logic code_bit;
    logic scr_bit;

    tx_pcs_framer u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .nib_en      (nib_en),
        .txd         (txd),
        .tx_en       (tx_en),
        .tx_er       (tx_er),
        .bypass_code (bypass_code),
        .ser_bit     (code_bit)
    );

    tx_pcs_scrambler #(
        .ADDR_W   (ADDR_W),
        .LFSR_W   (LFSR_W),
        .LFSR_TAP (LFSR_TAP)
    ) u_scr (
        .clk      (clk),
        .rst_n    (rst_n),
        .phy_addr (phy_addr),
        .bypass   (bypass_scr),
        .din      (code_bit),
        .dout     (scr_bit)
    );

    tx_pcs_mlt3 u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .sbit       (scr_bit),
        .line_plus  (line_plus),
        .line_minus (line_minus)
    );

    // R1: outputs are quiet in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!line_plus && !line_minus));

endmodule

// File: tb/tx_pcs_encoder_test.sv
module tx_pcs_encoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_en = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [4:0] phy_addr = 5'h0C;
    logic       bypass_code = 1'b0;
    logic       bypass_scr = 1'b1;
    logic       line_plus, line_minus;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    tx_pcs_encoder uut (
        .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .txd(txd),
        .tx_en(tx_en), .tx_er(tx_er), .phy_addr(phy_addr),
        .bypass_code(bypass_code), .bypass_scr(bypass_scr),
        .line_plus(line_plus), .line_minus(line_minus)
    );

    function automatic int cg_of(int n);
        case (n)
            0: return 'b11110;  1: return 'b01001;  2: return 'b10100;  3: return 'b10101;
            4: return 'b01010;  5: return 'b01011;  6: return 'b01110;  7: return 'b01111;
            8: return 'b10010;  9: return 'b10011; 10: return 'b10110; 11: return 'b10111;
           12: return 'b11010; 13: return 'b11011; 14: return 'b11100; default: return 'b11101;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int bq[$];
    int m_s, m_ph, m_fs, m_pend, m_valid = 0;

    function automatic int seed_of(int a);
        int v = 0;
        for (int i = 0; i < 11; i++) v |= ((a >> (i % 5)) & 1) << i;
        if (v == 0) v = 'h7FF;
        return v;
    endfunction

    always @(posedge clk) begin
        int b, k, sb, code;
        if (!rst_n) begin
            bq.delete();
            m_s = seed_of(phy_addr); m_ph = 0; m_fs = 0; m_pend = 0; m_valid = 1;
        end else begin
            b = (bq.size() > 0) ? bq.pop_front() : 0;
            k = ((m_s >> 10) ^ (m_s >> 8)) & 1;
            m_s = ((m_s << 1) | k) & 'h7FF;
            sb = b ^ (bypass_scr ? 0 : k);
            if (m_pend != 0) m_ph = (m_ph + 1) % 4;
            m_pend = sb;
            if (nib_en) begin
                code = 'b11111;
                case (m_fs)
                    0: if (tx_en) begin code = 'b11000; m_fs = 1; end
                    1: begin code = 'b10001; m_fs = 2; end
                    2: if (!tx_en) begin code = 'b01101; m_fs = 3; end
                       else code = tx_er ? 'b00100 : cg_of(txd);
                    default: begin code = 'b00111; m_fs = 0; end
                endcase
                if (bypass_code) code = {27'd0, tx_er, txd};
                bq.delete();
                for (int i = 4; i >= 0; i--) bq.push_back((code >> i) & 1);
            end
        end
    end

    // per-cycle compare and bit recovery from the line levels
    int rec[$];
    bit rec_on = 0;
    int prev_lvl = 0;

    always @(negedge clk) begin
        int lvl;
        if (m_valid) begin
            chk(line_plus == (m_ph == 1) && line_minus == (m_ph == 3),
                cur_req, {line_plus, line_minus}, {(m_ph == 1), (m_ph == 3)});
            chk(!(line_plus && line_minus), "R8", {line_plus, line_minus}, 0);
        end
        lvl = line_plus ? 1 : (line_minus ? -1 : 0);
        if (rec_on) rec.push_back(lvl != prev_lvl ? 1 : 0);
        prev_lvl = lvl;
    end

    function automatic int find_pat(int val, int len);
        for (int j = 0; j + len <= rec.size(); j++) begin
            bit hit = 1;
            for (int i = 0; i < len; i++)
                if (rec[j+i] != ((val >> (len - 1 - i)) & 1)) hit = 0;
            if (hit) return j;
        end
        return -1;
    endfunction

    function automatic int grp_at(int idx);
        int v = 0;
        for (int i = 0; i < 5; i++) v = (v << 1) | ((idx + i < rec.size()) ? rec[idx+i] : 0);
        return v;
    endfunction

    task automatic sym(input bit en, input bit er, input int d);
        @(negedge clk);
        nib_en = 1'b1; tx_en = en; tx_er = er; txd = d[3:0];
        @(negedge clk);
        nib_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; nib_en = 1'b0; tx_en = 1'b0; tx_er = 1'b0;
        repeat (3) @(negedge clk);
        chk(!line_plus && !line_minus, "R1", {line_plus, line_minus}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!line_plus && !line_minus, "R1", {line_plus, line_minus}, 0);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int j;
        int exp_g[$];
        int dat[$];

        // plain frame, keystream bypassed
        cur_req = "R1";
        do_reset();
        cur_req = "R3";
        rec.delete(); rec_on = 1;
        repeat (3) sym(0, 0, 0);
        dat = '{5, 5, 5, 5, 5, 13, 3, 10, 0, 15, 7};
        foreach (dat[i]) sym(1, 0, dat[i]);
        repeat (4) sym(0, 0, 0);
        rec_on = 0;
        j = find_pat('b1100010001, 10);
        chk(j >= 0, "R2", j, 0);
        exp_g.delete();
        for (int i = 2; i < dat.size(); i++) exp_g.push_back(cg_of(dat[i]));
        exp_g.push_back('b01101); exp_g.push_back('b00111); exp_g.push_back('b11111);
        if (j >= 0) begin
            foreach (exp_g[i]) begin
                if (i < exp_g.size() - 3)
                    chk(grp_at(j + 10 + 5*i) == exp_g[i], "R3", grp_at(j + 10 + 5*i), exp_g[i]);
                else
                    chk(grp_at(j + 10 + 5*i) == exp_g[i], "R5", grp_at(j + 10 + 5*i), exp_g[i]);
            end
        end

        // frame with an error nibble
        cur_req = "R4";
        rec.delete(); rec_on = 1;
        sym(1, 0, 5); sym(1, 0, 5); sym(1, 0, 5); sym(1, 1, 6); sym(1, 0, 1);
        repeat (4) sym(0, 0, 0);
        rec_on = 0;
        j = find_pat('b1100010001, 10);
        chk(j >= 0, "R2", j, 0);
        if (j >= 0) begin
            chk(grp_at(j + 10) == 'b01011, "R3", grp_at(j + 10), 'b01011);
            chk(grp_at(j + 15) == 'b00100, "R4", grp_at(j + 15), 'b00100);
            chk(grp_at(j + 20) == 'b01001, "R3", grp_at(j + 20), 'b01001);
            chk(grp_at(j + 25) == 'b01101, "R5", grp_at(j + 25), 'b01101);
            chk(grp_at(j + 30) == 'b00111, "R5", grp_at(j + 30), 'b00111);
        end

        // keystream on, zero address (forced seed)
        cur_req = "R6";
        bypass_scr = 1'b0; phy_addr = 5'h00;
        do_reset();
        repeat (6) sym(0, 0, 0);
        foreach (dat[i]) sym(1, 0, dat[i]);
        repeat (6) sym(0, 0, 0);

        // keystream on, another address, back-to-back frames
        cur_req = "R7";
        phy_addr = 5'h13;
        do_reset();
        repeat (4) sym(0, 0, 0);
        for (int f = 0; f < 3; f++) begin
            for (int i = 0; i < 8; i++) sym(1, (i == 5), (i * 3 + f) & 15);
            sym(0, 0, 0);
        end
        repeat (6) sym(0, 0, 0);

        // raw groups, keystream bypassed
        cur_req = "R9";
        bypass_scr = 1'b1; bypass_code = 1'b1;
        rec.delete(); rec_on = 1;
        sym(0, 0, 0); sym(1, 1, 6); sym(0, 0, 15); sym(1, 0, 1); sym(0, 0, 0); sym(0, 0, 0);
        rec_on = 0;
        j = find_pat('b101100111100001, 15);
        chk(j >= 0, "R9", j, 0);

        // raw groups with keystream on
        cur_req = "R10";
        bypass_scr = 1'b0;
        for (int i = 0; i < 20; i++) sym(i[0], i[1], i);
        bypass_code = 1'b0;
        repeat (4) sym(0, 0, 0);

        cur_req = "R11";
        bypass_scr = 1'b1;
        repeat (4) sym(1, 0, 9);
        repeat (4) sym(0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule